// File: doc/BRIEF.md
# Serial Audio Frame and Bit Clock Generator

This block produces the word-select (frame) clock and the bit clock of a serial audio link when the device owns the link as clock master. Both clocks are derived from one internal master clock, so the block runs entirely in the master-clock domain and treats its two outputs as registered data, with an output-enable for the pads.

The block has two rate modes, chosen by one mode bit. In integer mode only the low byte `N` of the divider input is used, and one frame lasts exactly `16*N` master cycles. In fractional mode all 15 bits `D` of the divider feed a 22-bit phase accumulator, and the average frame rate is `fclk*D/2^26`. This mode covers sample rates that do not divide the master clock evenly. In both modes a single modulo accumulator places bit-clock edges, so every frame holds exactly `BCLK_PER_FRAME` bit-clock periods.

A frame opens with the frame clock at its "left" level, which equals the invert input. The frame clock moves to the other level after half the bit periods. A one-cycle start strobe marks the cycle in which the frame clock returns to the left level.

Top module: `frameClockGen`

## Requirements
- R1: In integer mode (`intMode`=1) with low byte N of `divVal` in 4..255, the spacing between successive `frameStart` pulses is exactly 16*N master-clock cycles.
- R2: In integer mode, bits 14:8 of `divVal` have no effect on the frame period or on the clocks.
- R3: With `masterEn`=1, if the active divider is zero (low byte zero in integer mode, or the full 15-bit value zero in fractional mode), `bitClk` stays 0 and `frameStart` stays 0.
- R4: In fractional mode (`intMode`=0) with D = `divVal` nonzero, K frames span K*2^26/D master cycles to within 2 cycles. For D = 0x4000 this is exactly 4096 cycles per frame.
- R5: Every frame contains exactly `BCLK_PER_FRAME` (default 32) rising edges of `bitClk`.
- R6: During the first half of each frame `frameClk` equals `frameInv`, and during the second half it equals the opposite level. The two halves contain an equal number of bit periods, which in integer mode is exactly 8*N cycles per half. `frameClk` only changes in a cycle where `bitClk` has just fallen, unless `frameInv` changed.
- R7: `frameStart` is high for one cycle per frame, and in that cycle `frameClk` equals `frameInv`.
- R8: `driveEn` follows `masterEn` one cycle later. While `driveEn` is 0, `bitClk` and `frameStart` are 0 and no clock activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| intMode | input | 1 | 1 = integer divider, 0 = fractional accumulator |
| divVal | input | 15 | Divider value; only bits 7:0 are used in integer mode |
| masterEn | input | 1 | Enables clock generation as link master |
| frameInv | input | 1 | Frame clock level during the first (left) half of a frame |
| bitClk | output | 1 | Generated bit clock |
| frameClk | output | 1 | Generated frame clock |
| frameStart | output | 1 | One-cycle strobe at each frame boundary |
| driveEn | output | 1 | Output enable for both clock pads |

## Verification
Integer mode is tried with N = 4, where the bit clock toggles every cycle and the rate is at its limit, and with N = 10, where the edge spacing is uneven. This separates an off-by-one in the modulus from a mistake in edge placement. Repeating N = 10 with the upper divider bits set shows whether they leak into the period. Fractional mode is run with D = 0x4000, where a frame must take exactly 4096 cycles, and with D = 0x7FFF, where only the average can be right; this separates a wrong overflow width from a wrong increment. Zero dividers in each mode, the invert input and master disable cover the idle paths and the polarity of the frame halves.

// File: rtl/frameClkPkg.sv
package frameClkPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic run;    // advance the phase accumulator this cycle
    logic clear;  // return the accumulator to zero
  } ctlStrobe_t;
endpackage

// File: rtl/frameClkAccum.sv
module frameClkAccum
  import frameClkPkg::*;
#(
  parameter int DIV_W          = 15,
  parameter int INT_W          = 8,
  parameter int ACC_W          = 22,
  parameter int BCLK_PER_FRAME = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intMode,
  input  logic [DIV_W-1:0] divVal,
  input  ctlStrobe_t       strobe,
  output logic             edgeTick
);
  localparam int SUM_W     = ACC_W + 2;
  localparam int EDGES     = 2 * BCLK_PER_FRAME;
  // fractional step: edge rate = 2*B*fs with fs = fclk*D/2^(ACC_W+4)
  localparam int FRAC_MULT = BCLK_PER_FRAME / 8;

  logic [SUM_W-1:0] accQ, incVal, modVal, sumVal;
  logic             wrapNow;

  always_comb begin
    if (intMode) begin
      incVal = SUM_W'(EDGES);
      modVal = SUM_W'(divVal[INT_W-1:0]) << 4;
    end else begin
      incVal = SUM_W'(divVal) * SUM_W'(FRAC_MULT);
      modVal = SUM_W'(1) << ACC_W;
    end
    sumVal  = accQ + incVal;
    wrapNow = (sumVal >= modVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      edgeTick <= 1'b0;
    end else if (strobe.clear) begin
      accQ     <= '0;
      edgeTick <= 1'b0;
    end else if (strobe.run) begin
      accQ     <= wrapNow ? (sumVal - modVal) : sumVal;
      edgeTick <= wrapNow;
    end else begin
      edgeTick <= 1'b0;
    end
  end
endmodule

// File: rtl/frameClkSeq.sv
module frameClkSeq
  import frameClkPkg::*;
#(
  parameter int DIV_W          = 15,
  parameter int INT_W          = 8,
  parameter int BCLK_PER_FRAME = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intMode,
  input  logic [DIV_W-1:0] divVal,
  input  logic             masterEn,
  input  logic             frameInv,
  input  logic             edgeTick,
  output ctlStrobe_t       strobe,
  output logic             bitClk,
  output logic             frameClk,
  output logic             frameStart,
  output logic             driveEn
);
  localparam int EDGES = 2 * BCLK_PER_FRAME;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);
  localparam logic [CNT_W-1:0] HALF_EDGE = CNT_W'(BCLK_PER_FRAME - 1);

  logic             divNonZero, active;
  logic [CNT_W-1:0] edgeCnt;
  logic             rightHalf, bitClkQ, startQ, driveQ;

  always_comb begin
    divNonZero   = intMode ? (divVal[INT_W-1:0] != '0) : (divVal != '0);
    active       = masterEn && divNonZero;
    strobe.run   = active;
    strobe.clear = !active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ    <= 1'b0;
      bitClkQ   <= 1'b0;
      edgeCnt   <= '0;
      rightHalf <= 1'b0;
      startQ    <= 1'b0;
    end else begin
      driveQ <= masterEn;
      if (!active) begin
        bitClkQ   <= 1'b0;
        edgeCnt   <= '0;
        rightHalf <= 1'b0;
        startQ    <= 1'b0;
      end else begin
        startQ <= 1'b0;
        if (edgeTick) begin
          bitClkQ <= ~bitClkQ;
          if (edgeCnt == LAST_EDGE) begin
            edgeCnt   <= '0;
            rightHalf <= 1'b0;
            startQ    <= 1'b1;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == HALF_EDGE) rightHalf <= 1'b1;
          end
        end
      end
    end
  end

  assign bitClk     = bitClkQ;
  assign frameClk   = rightHalf ^ frameInv;
  assign frameStart = startQ;
  assign driveEn    = driveQ;
endmodule

// File: rtl/frameClockGen.sv
module frameClockGen
  import frameClkPkg::*;
#(
  parameter int DIV_W          = 15,
  parameter int INT_W          = 8,
  parameter int ACC_W          = 22,
  parameter int BCLK_PER_FRAME = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intMode,
  input  logic [DIV_W-1:0] divVal,
  input  logic             masterEn,
  input  logic             frameInv,
  output logic             bitClk,
  output logic             frameClk,
  output logic             frameStart,
  output logic             driveEn
);
  ctlStrobe_t strobe;
  logic       edgeTick;

  frameClkAccum #(
    .DIV_W(DIV_W), .INT_W(INT_W), .ACC_W(ACC_W), .BCLK_PER_FRAME(BCLK_PER_FRAME)
  ) u_accum (
    .clk(clk), .rstN(rstN), .intMode(intMode), .divVal(divVal),
    .strobe(strobe), .edgeTick(edgeTick)
  );

  frameClkSeq #(
    .DIV_W(DIV_W), .INT_W(INT_W), .BCLK_PER_FRAME(BCLK_PER_FRAME)
  ) u_seq (
    .clk(clk), .rstN(rstN), .intMode(intMode), .divVal(divVal),
    .masterEn(masterEn), .frameInv(frameInv), .edgeTick(edgeTick),
    .strobe(strobe), .bitClk(bitClk), .frameClk(frameClk),
    .frameStart(frameStart), .driveEn(driveEn)
  );
endmodule

// File: rtl/frameClockGenChecker.sv
module frameClockGenChecker #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             intMode,
  input logic [DIV_W-1:0] divVal,
  input logic             masterEn,
  input logic             frameInv,
  input logic             bitClk,
  input logic             frameClk,
  input logic             frameStart,
  input logic             driveEn
);
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  p_start_left_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (frameClk == frameInv));

  p_frame_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(frameClk) && $stable(frameInv)) |-> (!bitClk && $past(bitClk)));

  p_drive_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    masterEn |=> driveEn);

  p_drive_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |=> (!driveEn && !bitClk && !frameStart));

  p_zero_int_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && divVal[7:0] == 8'd0) |=> !frameStart);

  p_zero_frac_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!intMode && divVal == '0) |=> !frameStart);
endmodule

bind frameClockGen frameClockGenChecker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/frameClockGen_bench.sv
module frameClockGen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intMode = 1'b1;
  logic [14:0] divVal = '0;
  logic        masterEn = 1'b0;
  logic        frameInv = 1'b0;
  logic        bitClk, frameClk, frameStart, driveEn;

  int vecCount = 0;
  int missCount = 0;
  int cycleCount = 0;
  bit done = 0;

  frameClockGen u_frameClockGen (
    .clk(clk), .rstN(rstN), .intMode(intMode), .divVal(divVal),
    .masterEn(masterEn), .frameInv(frameInv), .bitClk(bitClk),
    .frameClk(frameClk), .frameStart(frameStart), .driveEn(driveEn)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic mode, input logic [14:0] dv, input logic inv);
    @(negedge clk);
    masterEn = 1'b0;
    repeat (3) @(negedge clk);
    intMode  = mode;
    divVal   = dv;
    frameInv = inv;
    masterEn = 1'b1;
  endtask

  // Sync to a frame start, then count K further frames
  task automatic runFrames(input int k, output int cyc, output int rises,
                           output int left, output bit ok, output bit startLevelOk);
    int frames = 0;
    int guard = 0;
    logic prevB;
    cyc = 0; rises = 0; left = 0; ok = 0; startLevelOk = 0;
    while (!frameStart && guard < 60000) begin @(negedge clk); guard++; end
    if (!frameStart) return;
    startLevelOk = (frameClk == frameInv);
    prevB = bitClk;
    while (frames < k && guard < 120000) begin
      @(negedge clk);
      guard++;
      cyc++;
      if (bitClk && !prevB) rises++;
      prevB = bitClk;
      if (frameClk == frameInv) left++;
      if (frameStart) frames++;
    end
    ok = (frames == k);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(bitClk == 1'b0, "R8 reset bitClk", bitClk, 0);
    check(frameStart == 1'b0, "R8 reset frameStart", frameStart, 0);
    check(driveEn == 1'b0, "R8 reset driveEn", driveEn, 0);
  endtask

  task automatic testIntFast();
    int c, r, l; bit ok, sl;
    configure(1'b1, 15'd4, 1'b0);
    runFrames(4, c, r, l, ok, sl);
    check(ok && c == 256, "R1 int N=4 cycles for 4 frames", c, 256);
    check(r == 128, "R5 int N=4 bit rises", r, 128);
    check(l == 128, "R6 int N=4 left cycles", l, 128);
  endtask

  task automatic testIntUpperBits();
    int c, r, l; bit ok, sl;
    configure(1'b1, {7'h00, 8'd10}, 1'b0);
    runFrames(4, c, r, l, ok, sl);
    check(ok && c == 640, "R1 int N=10 cycles", c, 640);
    check(l == 320, "R6 int N=10 left cycles", l, 320);
    configure(1'b1, {7'h55, 8'd10}, 1'b0);
    runFrames(4, c, r, l, ok, sl);
    check(ok && c == 640, "R2 upper bits ignored cycles", c, 640);
    check(r == 128, "R2 upper bits ignored rises", r, 128);
  endtask

  task automatic testZeroDiv();
    int starts = 0;
    int highs = 0;
    configure(1'b1, {7'h7F, 8'h00}, 1'b0);
    repeat (1000) begin
      @(negedge clk);
      if (frameStart) starts++;
      if (bitClk) highs++;
    end
    check(starts == 0 && highs == 0, "R3 int low byte zero idle", starts + highs, 0);
    starts = 0; highs = 0;
    configure(1'b0, 15'd0, 1'b0);
    repeat (1000) begin
      @(negedge clk);
      if (frameStart) starts++;
      if (bitClk) highs++;
    end
    check(starts == 0 && highs == 0, "R3 frac zero idle", starts + highs, 0);
  endtask

  task automatic testFrac();
    int c, r, l; bit ok, sl;
    real expd;
    configure(1'b0, 15'h4000, 1'b0);
    runFrames(4, c, r, l, ok, sl);
    check(ok && c == 16384, "R4 frac D=0x4000 exact cycles", c, 16384);
    check(r == 128, "R5 frac D=0x4000 bit rises", r, 128);
    configure(1'b0, 15'h7FFF, 1'b0);
    runFrames(8, c, r, l, ok, sl);
    expd = 8.0 * 67108864.0 / 32767.0;
    check(ok && (c - expd) <= 2.0 && (expd - c) <= 2.0,
          "R4 frac D=0x7FFF average cycles", c, longint'(expd));
    check(r == 256, "R5 frac D=0x7FFF bit rises", r, 256);
  endtask

  task automatic testInvert();
    int c, r, l; bit ok, sl;
    configure(1'b1, 15'd8, 1'b1);
    runFrames(4, c, r, l, ok, sl);
    check(sl, "R7 frame clock at left level on start", frameClk, frameInv);
    check(ok && l == 256, "R6 inverted left-level cycles", l, 256);
    check(c == 512, "R1 int N=8 cycles", c, 512);
  endtask

  task automatic testDisable();
    int acts = 0;
    @(negedge clk);
    masterEn = 1'b0;
    intMode = 1'b1;
    divVal = 15'd4;
    @(negedge clk);
    check(driveEn == 1'b0, "R8 driveEn drops after disable", driveEn, 0);
    repeat (500) begin
      @(negedge clk);
      if (bitClk || frameStart || driveEn) acts++;
    end
    check(acts == 0, "R8 no activity while disabled", acts, 0);
    masterEn = 1'b1;
    @(negedge clk);
    check(driveEn == 1'b1, "R8 driveEn one cycle after enable", driveEn, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIntFast();
    testIntUpperBits();
    testZeroDiv();
    testFrac();
    testInvert();
    testDisable();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    wait (cycleCount > 190000);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCount, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule